// File: doc/BRIEF.md
# Triggered Bit-Pattern Pulse Sequencer

This block is one channel of a pulse pattern generator that runs on a divided RF clock and is locked to an external trigger. Two bit memories hold the pattern, one bit per clock cycle of a revolution. The first memory marks the cycles that should raise an external set/reset flip-flop. The second marks the cycles that should clear it. Both memories are loaded through a plain word-write port, and a clear command can zero all of a memory or only its leading words.

Once armed, the channel waits for a rising edge on the trigger. It then lets a programmable number of latency cycles pass. After that it steps through both memories in lockstep, one bit per cycle, until the revolution length is reached. Each 1 bit produces a one-cycle strobe on the matching output. The channel can run stopped, continuous (re-arming after every revolution) or one-shot (stopping itself after a single revolution). An output-enable bit, held apart from the mode, tells the pad logic whether to drive the strobes or float them.

Top module: `pulse_seq_top`

## Requirements
- R1: After reset the state is Stop, both strobes, `running`, `driveEn` and `writeErr` are 0, and both memories read as all zeros.
- R2: A control write with mode 0 stops the channel, mode 1 selects continuous and mode 2 selects one-shot. `running` is 1 exactly while the stored mode is nonzero. A nonzero mode moves Stop to WaitForTrigger one cycle after it is stored. A stored mode of 0 forces Stop on the next edge from any state.
- R3: The trigger passes through two synchroniser flops and is then edge-detected. A rise that is set up before clock edge k puts the state into Generating at edge k+2. A trigger held high does not fire again.
- R4: Generating lasts `latency`+1 cycles, after which the state becomes Outputting at cycle index 0.
- R5: In an Outputting cycle at index n, `setStrobe` (or `resetStrobe`) is 1 in the following cycle exactly when bit n of the set (or reset) memory is 1. Bit n lives in word n / WORD_W at bit position n mod WORD_W. Strobes are 0 at all other times.
- R6: Outputting lasts `overflow` cycles (indices 0 to `overflow`-1). An `overflow` of 0 behaves as 1. Indices at or beyond WORDS*WORD_W read as 0.
- R7: At the end of a revolution, continuous mode returns to WaitForTrigger. One-shot mode goes to Stop and sets the stored mode to 0, so `running` falls and later triggers have no effect.
- R8: A trigger edge that arrives during Generating or Outputting is ignored and does not shorten or restart the revolution.
- R9: Memory writes and clears take effect only when the state is Stop and the stored mode is 0. Any other write or clear is dropped and sets `writeErr`, which stays 1 until reset.
- R10: A clear zeroes the memories selected by `clrSel` (bit 0 = set memory, bit 1 = reset memory). A `clrCount` of 0 clears every word, and a `clrCount` of N clears words 0 to N-1 only.
- R11: `driveEn` follows the output-enable bit of the last control write, independent of the mode.
- R12: `dbgState` encodes Stop = 0, WaitForTrigger = 1, Generating = 2, Outputting = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided RF clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | External trigger, asynchronous |
| ctlWrEn | input | 1 | Write strobe for mode and output enable |
| ctlMode | input | 2 | Mode: 0 stopped, 1 continuous, 2 one-shot |
| ctlOutEn | input | 1 | Output-enable bit to store |
| latency | input | LAT_W | Cycles between trigger and playback start |
| overflow | input | CNT_W | Revolution length in cycles |
| memWrEn | input | 1 | Memory word write strobe |
| memWrSel | input | 1 | 0 selects set memory, 1 selects reset memory |
| memWrAddr | input | ADDR_W | Word address |
| memWrData | input | WORD_W | Word data |
| clrEn | input | 1 | Clear command strobe |
| clrSel | input | 2 | Memories to clear |
| clrCount | input | ADDR_W+1 | Words to clear from 0, 0 means all |
| setStrobe | output | 1 | One-cycle set pulse |
| resetStrobe | output | 1 | One-cycle reset pulse |
| driveEn | output | 1 | Pad drive enable (0 = high impedance) |
| running | output | 1 | Stored mode is nonzero |
| writeErr | output | 1 | Sticky dropped-write flag |
| dbgState | output | 3 | Channel state index |

## Verification
The bench builds the channel with WORDS=4, WORD_W=8, CNT_W=8 and LAT_W=4. With these values the pattern capacity is only 32 bits, so a revolution of 40 cycles runs past the end of the memories. Word boundaries at bits 8 and 16 are also crossed within a short playback. A partial clear of a single word leaves later words visibly intact. The narrow latency field lets both zero and nonzero latency be checked quickly, and the narrow revolution counter makes the zero-length case cheap to reach.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  typedef enum logic [2:0] {
    ST_STOP = 3'd0,
    ST_WAIT = 3'd1,
    ST_GEN  = 3'd2,
    ST_OUT  = 3'd3
  } seqState_e;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_ONCE = 2'd2;

  typedef struct packed {
    logic memWr;
    logic memClr;
    logic play;
  } seqCmd_t;
endpackage

// File: rtl/pulse_seq_ctrl.sv
module pulse_seq_ctrl
  import pulse_seq_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             ctlWrEn,
  input  logic [1:0]       ctlMode,
  input  logic             ctlOutEn,
  input  logic [LAT_W-1:0] latency,
  input  logic [CNT_W-1:0] overflow,
  input  logic             memWrReq,
  input  logic             clrReq,
  output seqCmd_t          cmd,
  output logic [CNT_W-1:0] playIdx,
  output logic [2:0]       stateOut,
  output logic             running,
  output logic             driveEn,
  output logic             writeErr
);
  seqState_e        stQ;
  logic [1:0]       modeQ;
  logic             oeQ;
  logic             errQ;
  logic [LAT_W-1:0] latQ;
  logic [CNT_W-1:0] idxQ;
  logic [2:0]       syncQ;   // [0] first stage, [1] second stage, [2] previous
  logic             trigEdge;
  logic             stopped;
  logic             lastIdx;

  assign trigEdge = syncQ[1] & ~syncQ[2];
  assign stopped  = (stQ == ST_STOP) && (modeQ == MODE_OFF);
  assign lastIdx  = ({1'b0, idxQ} + 1'b1) >= {1'b0, overflow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_STOP;
      modeQ <= MODE_OFF;
      oeQ   <= 1'b0;
      errQ  <= 1'b0;
      latQ  <= '0;
      idxQ  <= '0;
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[1:0], trigIn};
      if ((memWrReq || clrReq) && !stopped) errQ <= 1'b1;
      if (modeQ == MODE_OFF) begin
        stQ <= ST_STOP;
      end else begin
        unique case (stQ)
          ST_STOP: stQ <= ST_WAIT;
          ST_WAIT: if (trigEdge) begin
            stQ  <= ST_GEN;
            latQ <= '0;
          end
          ST_GEN: if (latQ == latency) begin
            stQ  <= ST_OUT;
            idxQ <= '0;
          end else begin
            latQ <= latQ + 1'b1;
          end
          ST_OUT: if (lastIdx) begin
            if (modeQ == MODE_ONCE) begin
              stQ   <= ST_STOP;
              modeQ <= MODE_OFF;
            end else begin
              stQ <= ST_WAIT;
            end
          end else begin
            idxQ <= idxQ + 1'b1;
          end
          default: stQ <= ST_STOP;
        endcase
      end
      if (ctlWrEn) begin
        modeQ <= ctlMode;
        oeQ   <= ctlOutEn;
      end
    end
  end

  always_comb begin
    cmd.memWr  = memWrReq && stopped;
    cmd.memClr = clrReq && stopped;
    cmd.play   = (stQ == ST_OUT);
  end

  assign playIdx  = idxQ;
  assign stateOut = stQ;
  assign running  = (modeQ != MODE_OFF);
  assign driveEn  = oeQ;
  assign writeErr = errQ;
endmodule

// File: rtl/pulse_seq_mem.sv
module pulse_seq_mem
  import pulse_seq_pkg::*;
#(
  parameter int WORDS  = 2048,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int IDX_W  = ADDR_W + BIT_W,
  localparam int CLR_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [CNT_W-1:0]  playIdx,
  input  logic              wrSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        clrSel,
  input  logic [CLR_W-1:0]  clrCount,
  output logic              setStrobe,
  output logic              resetStrobe
);
  logic [ADDR_W-1:0] wordIdx;
  logic [BIT_W-1:0]  bitIdx;
  logic              inRange;
  logic [1:0]        bitVal;

  assign wordIdx = playIdx[IDX_W-1:BIT_W];
  assign bitIdx  = playIdx[BIT_W-1:0];

  generate
    if (CNT_W > IDX_W) begin : g_range
      assign inRange = ~|playIdx[CNT_W-1:IDX_W];
    end else begin : g_full
      assign inRange = 1'b1;
    end
  endgenerate

  // bank 0 holds set bits, bank 1 holds reset bits
  generate
    for (genvar m = 0; m < 2; m++) begin : g_bank
      logic [WORD_W-1:0] mem [WORDS];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
          if (cmd.memClr && clrSel[m]) begin
            for (int w = 0; w < WORDS; w++)
              if (clrCount == '0 || CLR_W'(w) < clrCount) mem[w] <= '0;
          end
          if (cmd.memWr && (wrSel == 1'(m))) mem[wrAddr] <= wrData;
        end
      end
      assign bitVal[m] = inRange && mem[wordIdx][bitIdx];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setStrobe   <= 1'b0;
      resetStrobe <= 1'b0;
    end else begin
      setStrobe   <= cmd.play && bitVal[0];
      resetStrobe <= cmd.play && bitVal[1];
    end
  end
endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top
  import pulse_seq_pkg::*;
#(
  parameter int WORDS  = 2048,
  parameter int WORD_W = 32,
  parameter int LAT_W  = 8,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigIn,
  input  logic              ctlWrEn,
  input  logic [1:0]        ctlMode,
  input  logic              ctlOutEn,
  input  logic [LAT_W-1:0]  latency,
  input  logic [CNT_W-1:0]  overflow,
  input  logic              memWrEn,
  input  logic              memWrSel,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [WORD_W-1:0] memWrData,
  input  logic              clrEn,
  input  logic [1:0]        clrSel,
  input  logic [ADDR_W:0]   clrCount,
  output logic              setStrobe,
  output logic              resetStrobe,
  output logic              driveEn,
  output logic              running,
  output logic              writeErr,
  output logic [2:0]        dbgState
);
  seqCmd_t          cmd;
  logic [CNT_W-1:0] playIdx;

  pulse_seq_ctrl #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .ctlWrEn(ctlWrEn), .ctlMode(ctlMode), .ctlOutEn(ctlOutEn),
    .latency(latency), .overflow(overflow),
    .memWrReq(memWrEn), .clrReq(clrEn),
    .cmd(cmd), .playIdx(playIdx), .stateOut(dbgState),
    .running(running), .driveEn(driveEn), .writeErr(writeErr)
  );

  pulse_seq_mem #(.WORDS(WORDS), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_mem (
    .clk(clk), .rstN(rstN), .cmd(cmd), .playIdx(playIdx),
    .wrSel(memWrSel), .wrAddr(memWrAddr), .wrData(memWrData),
    .clrSel(clrSel), .clrCount(clrCount),
    .setStrobe(setStrobe), .resetStrobe(resetStrobe)
  );
endmodule

// File: rtl/pulse_seq_checker.sv
module pulse_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       setStrobe,
  input logic       resetStrobe,
  input logic       running,
  input logic       writeErr,
  input logic [2:0] dbgState
);
  a_r5_strobe_after_out: assert property (@(posedge clk) disable iff (!rstN)
    (setStrobe || resetStrobe) |-> ($past(dbgState) == 3'd3));
  a_r12_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    dbgState <= 3'd3);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    writeErr |=> writeErr);
  a_r2_off_forces_stop: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (dbgState == 3'd0));
  a_r8_no_restart_in_out: assert property (@(posedge clk) disable iff (!rstN)
    (dbgState == 3'd3) |=> (dbgState != 3'd2));
  a_r4_gen_leads_to_out: assert property (@(posedge clk) disable iff (!rstN)
    (dbgState == 3'd2) |=> (dbgState == 3'd0 || dbgState == 3'd2 || dbgState == 3'd3));
endmodule

bind pulse_seq_top pulse_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .setStrobe(setStrobe), .resetStrobe(resetStrobe),
  .running(running), .writeErr(writeErr), .dbgState(dbgState)
);

// File: tb/tb_pulse_seq_top.sv
module tb_pulse_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4, WORD_W = 8, LAT_W = 4, CNT_W = 8;
  localparam int CAP = WORDS * WORD_W;

  logic clk = 1'b0, rstN = 1'b0, trigIn = 1'b0;
  logic ctlWrEn = 1'b0, ctlOutEn = 1'b0;
  logic [1:0] ctlMode = 2'd0;
  logic [LAT_W-1:0] latency = '0;
  logic [CNT_W-1:0] overflow = '0;
  logic memWrEn = 1'b0, memWrSel = 1'b0;
  logic [1:0] memWrAddr = '0;
  logic [WORD_W-1:0] memWrData = '0;
  logic clrEn = 1'b0;
  logic [1:0] clrSel = '0;
  logic [2:0] clrCount = '0;
  logic setStrobe, resetStrobe, driveEn, running, writeErr;
  logic [2:0] dbgState;

  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_seq_top #(.WORDS(WORDS), .WORD_W(WORD_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .ctlWrEn(ctlWrEn), .ctlMode(ctlMode),
    .ctlOutEn(ctlOutEn), .latency(latency), .overflow(overflow), .memWrEn(memWrEn),
    .memWrSel(memWrSel), .memWrAddr(memWrAddr), .memWrData(memWrData), .clrEn(clrEn),
    .clrSel(clrSel), .clrCount(clrCount), .setStrobe(setStrobe), .resetStrobe(resetStrobe),
    .driveEn(driveEn), .running(running), .writeErr(writeErr), .dbgState(dbgState)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int mState, mMode, mOe, mErr, mSet, mRes, mLat, mIdx, ms1, ms2, mpv;
  int setMem[CAP], resMem[CAP];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mMode = 0; mOe = 0; mErr = 0; mSet = 0; mRes = 0;
      mLat = 0; mIdx = 0; ms1 = 0; ms2 = 0; mpv = 0;
      foreach (setMem[b]) begin setMem[b] = 0; resMem[b] = 0; end
    end else begin
      int ns, nm, nl, ni;
      bit edgeSeen, stopped;
      edgeSeen = (ms2 == 1) && (mpv == 0);
      stopped = (mState == 0) && (mMode == 0);
      mSet = (mState == 3 && mIdx < CAP) ? setMem[mIdx] : 0;
      mRes = (mState == 3 && mIdx < CAP) ? resMem[mIdx] : 0;
      if ((memWrEn || clrEn) && !stopped) mErr = 1;
      if (clrEn && stopped)
        for (int b = 0; b < CAP; b++)
          if (clrCount == 0 || (b / WORD_W) < int'(clrCount)) begin
            if (clrSel[0]) setMem[b] = 0;
            if (clrSel[1]) resMem[b] = 0;
          end
      if (memWrEn && stopped)
        for (int k = 0; k < WORD_W; k++)
          if (memWrSel == 1'b0) setMem[memWrAddr * WORD_W + k] = memWrData[k];
          else resMem[memWrAddr * WORD_W + k] = memWrData[k];
      ns = mState; nm = mMode; nl = mLat; ni = mIdx;
      if (mMode == 0) ns = 0;
      else case (mState)
        0: ns = 1;
        1: if (edgeSeen) begin ns = 2; nl = 0; end
        2: if (mLat == int'(latency)) begin ns = 3; ni = 0; end else nl = mLat + 1;
        3: if (mIdx + 1 >= int'(overflow)) begin
             if (mMode == 2) begin ns = 0; nm = 0; end else ns = 1;
           end else ni = mIdx + 1;
        default: ns = 0;
      endcase
      if (ctlWrEn) begin nm = ctlMode; mOe = ctlOutEn; end
      mState = ns; mMode = nm; mLat = nl; mIdx = ni;
      mpv = ms2; ms2 = ms1; ms1 = trigIn;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk("R5 setStrobe vs model", setStrobe, mSet);
      chk("R5 resetStrobe vs model", resetStrobe, mRes);
      chk("R12 state vs model", dbgState, mState);
      chk("R2 running vs model", running, mMode != 0);
      chk("R11 driveEn vs model", driveEn, mOe);
      chk("R9 writeErr vs model", writeErr, mErr);
    end
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic ctl(input logic [1:0] m, input logic oe);
    ctlMode = m; ctlOutEn = oe; ctlWrEn = 1'b1;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [1:0] a, input logic [WORD_W-1:0] d);
    memWrSel = sel; memWrAddr = a; memWrData = d; memWrEn = 1'b1;
    @(negedge clk); memWrEn = 1'b0;
  endtask

  task automatic clr(input logic [1:0] sel, input logic [2:0] n);
    clrSel = sel; clrCount = n; clrEn = 1'b1;
    @(negedge clk); clrEn = 1'b0;
  endtask

  // one trigger pulse, then measure Outputting length and strobe counts
  task automatic runOnce(output int outCyc, output int nSet, output int nRes);
    outCyc = 0; nSet = 0; nRes = 0;
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    for (int i = 0; i < 100 && dbgState != 3'd3; i++) @(negedge clk);
    while (1) begin
      nSet += int'(setStrobe); nRes += int'(resetStrobe);
      if (dbgState != 3'd3) break;
      outCyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    int oc, ns, nr, n;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", dbgState, 0);
    chk("R1 strobes in reset", {setStrobe, resetStrobe}, 0);
    chk("R1 flags in reset", {running, driveEn, writeErr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    wr(0, 0, 8'h05); wr(1, 0, 8'h08); wr(0, 1, 8'h80); wr(1, 2, 8'h01);
    latency = 4'd2; overflow = 8'd20;
    ctl(2'd1, 1'b1);
    @(negedge clk);
    chk("R2 continuous arms to wait", dbgState, 1);
    chk("R2 running set", running, 1);
    chk("R11 drive enabled", driveEn, 1);

    trigIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 R12 generating two edges after sync", dbgState, 2);
    repeat (3) @(negedge clk);
    chk("R4 outputting after latency+1", dbgState, 3);
    n = 1;
    while (1) begin
      @(negedge clk);
      if (n == 1) chk("R5 strobe for bit 0", setStrobe, 1);
      if (n == 3) trigIn = 1'b0;
      if (n == 5) trigIn = 1'b1;
      if (n == 6) trigIn = 1'b0;
      if (dbgState != 3'd3) break;
      n++;
    end
    chk("R6 R8 revolution length with late trigger", n, 20);
    chk("R7 continuous returns to wait", dbgState, 1);

    wr(0, 0, 8'hFF);
    chk("R9 error on write while running", writeErr, 1);
    runOnce(oc, ns, nr);
    chk("R9 pattern unchanged set pulses", ns, 3);
    chk("R5 reset pulses across word boundary", nr, 2);

    ctl(2'd0, 1'b1);
    @(negedge clk);
    chk("R2 stop on mode 0", dbgState, 0);
    chk("R2 running cleared", running, 0);

    latency = 4'd0; overflow = 8'd40;
    ctl(2'd2, 1'b0);
    chk("R11 drive follows bit not mode", driveEn, 0);
    runOnce(oc, ns, nr);
    chk("R6 length beyond capacity", oc, 40);
    chk("R6 bits beyond capacity read 0", ns, 3);
    @(negedge clk);
    chk("R7 one-shot stops", dbgState, 0);
    chk("R7 one-shot clears mode", running, 0);
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 trigger ignored after one-shot", dbgState, 0);

    clr(2'b01, 3'd1);
    latency = 4'd1; overflow = 8'd32;
    ctl(2'd1, 1'b1);
    runOnce(oc, ns, nr);
    chk("R10 partial clear keeps word 1", ns, 1);
    chk("R10 reset memory untouched", nr, 2);

    ctl(2'd0, 1'b1);
    repeat (3) @(negedge clk);
    clr(2'b11, 3'd0);
    ctl(2'd1, 1'b1);
    runOnce(oc, ns, nr);
    chk("R10 full clear set", ns, 0);
    chk("R10 full clear reset", nr, 0);

    overflow = 8'd0;
    repeat (2) @(negedge clk);
    runOnce(oc, ns, nr);
    chk("R6 overflow 0 acts as 1", oc, 1);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule